// File: doc/BRIEF.md
# Interrupt Gate with Privileged Enable Control

This block is the interrupt-control slice of a control coprocessor for a simple in-order core. It keeps a status word and a cause word and decides, on every clock, whether the core must take an interrupt exception. Eight external request lines pass through a synchronising stage and then land in the cause word. A request can fire only if its mask bit in the status word is set, and only through the upper six bits of the mask field. Two global enables must both be on, and the core must not already be in an exception or error state. When the gate fires, the block gives a one-cycle pulse with the vector offset, saves the current PC as the return address, and marks the core as being in an exception.

The decode stage gives the block a small operation code each cycle. The codes are: enable the secondary global interrupt bit, disable it, return from exception, or load the status word. The two enable/disable operations act only when the core has the right to change that bit: kernel mode, exception level, error level, or a dedicated permission bit. Otherwise they do nothing. A return from exception clears the exception level and sends the saved PC back as a redirect target. Any request that is still pending is then judged again on the next cycle.

Top module: `irq_gate_ctl`

## Requirements
- R1: While reset is held and in the cycle after it ends, status, cause and EPC read zero and neither the take pulse nor the redirect pulse is high.
- R2: Request line k appears in cause bit 8+k two clock edges after it changes. Cause bits outside 15:8 read zero.
- R3: Only cause bits 15:10 can cause an interrupt. Lines 0 and 1 (cause bits 8 and 9) never fire the gate, even with their status mask bits 8 and 9 set.
- R4: The gate fires only when (cause AND status AND 0xFC00) is non-zero, IE (status bit 0) is 1, the secondary enable (status bit 16) is 1, EXL (bit 1) is 0 and ERL (bit 2) is 0.
- R5: When the gate fires, take_o is high for exactly one cycle and vec_off_o shows 0x200 in that cycle. epc_o holds the PC given in the cycle that fired, and EXL is set in the same update, so the interrupt is not taken again while EXL stays set.
- R6: Operation code 1 (enable) sets status bit 16 when EXL, ERL, or the permission bit (status bit 17) is set, or when the mode field (status bits 4:3) is 00.
- R7: Operation code 2 (disable) clears status bit 16 under the same permission condition as R6.
- R8: Without that permission (mode field non-zero and bits 1, 2 and 17 all clear), operation codes 1 and 2 leave the status word unchanged.
- R9: Operation code 3 (return) clears EXL and pulses redirect_o for one cycle with redirect_pc_o equal to EPC. A request still pending afterwards is taken on the next evaluation.
- R10: If the gate fires in the same cycle as any operation code, the exception wins. The operation is dropped, and the only change to the status word is EXL being set.
- R11: Operation code 4 loads the whole status word from op_wdata_i. Code 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | 8 | External interrupt request lines |
| op_kind_i | input | 3 | Decoded operation: 0 none, 1 enable, 2 disable, 3 return, 4 status load |
| op_wdata_i | input | 32 | Status value for operation code 4 |
| pc_i | input | 32 | PC of the instruction in the current cycle |
| take_o | output | 1 | Interrupt exception taken (one-cycle pulse) |
| vec_off_o | output | 12 | Vector offset, valid with take_o |
| redirect_o | output | 1 | Return-from-exception redirect pulse |
| redirect_pc_o | output | 32 | Redirect target, valid with redirect_o |
| status_o | output | 32 | Current status word |
| cause_o | output | 32 | Current cause word |
| epc_o | output | 32 | Saved exception PC |

## Verification
The collision that matters is the gate firing in the same cycle as a decoded operation, and in particular a disable that arrives exactly when a pending request becomes visible in the cause word. The bench raises a request line and waits the synchronising delay. It then issues the disable on the cycle in which the cause bit first appears. It expects a taken exception with the secondary enable still set and EXL newly set. A return issued while the request is still high is used in a second way: it checks that the interrupt is re-taken one cycle after EXL clears and never in the same cycle as the return.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    // Status word field positions
    localparam int unsigned SR_IE     = 0;
    localparam int unsigned SR_EXL    = 1;
    localparam int unsigned SR_ERL    = 2;
    localparam int unsigned SR_KSU_LO = 3;
    localparam int unsigned SR_KSU_HI = 4;
    localparam int unsigned SR_EIE    = 16;
    localparam int unsigned SR_EDI    = 17;

    // Lowest cause bit receiving an external request
    localparam int unsigned CAUSE_IP_LO = 8;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_EI   = 3'd1,
        OP_DI   = 3'd2,
        OP_ERET = 3'd3,
        OP_MTSR = 3'd4
    } op_kind_e;

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
    parameter int unsigned NLINES = 8,
    parameter int unsigned STAGES = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NLINES-1:0] line_i,
    output logic [NLINES-1:0] line_o
);
    logic [NLINES-1:0] stage_q [STAGES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= line_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign line_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_priv_check.sv
module irq_priv_check
    import irq_gate_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] status_i,
    output logic            may_toggle_o
);
    logic kernel_mode;

    always_comb begin
        kernel_mode  = (status_i[SR_KSU_HI:SR_KSU_LO] == 2'b00);
        may_toggle_o = status_i[SR_EXL] | status_i[SR_ERL] |
                       status_i[SR_EDI] | kernel_mode;
    end
endmodule

// File: rtl/irq_take_logic.sv
module irq_take_logic
    import irq_gate_pkg::*;
#(
    parameter int unsigned     XLEN      = 32,
    parameter logic [XLEN-1:0] QUAL_MASK = 32'h0000_FC00
) (
    input  logic [XLEN-1:0] status_i,
    input  logic [XLEN-1:0] cause_i,
    output logic            pending_o,
    output logic            fire_o
);
    logic both_enabled;
    logic in_handler;

    always_comb begin
        pending_o    = |(cause_i & status_i & QUAL_MASK);
        both_enabled = status_i[SR_IE] & status_i[SR_EIE];
        in_handler   = status_i[SR_EXL] | status_i[SR_ERL];
        fire_o       = pending_o & both_enabled & ~in_handler;
    end
endmodule

// File: rtl/irq_gate_ctl.sv
module irq_gate_ctl
    import irq_gate_pkg::*;
#(
    parameter int unsigned      XLEN        = 32,
    parameter int unsigned      NLINES      = 8,
    parameter int unsigned      SYNC_STAGES = 1,
    parameter int unsigned      VEC_W       = 12,
    parameter logic [VEC_W-1:0] VEC_OFF     = 12'h200,
    parameter logic [XLEN-1:0]  QUAL_MASK   = 32'h0000_FC00
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NLINES-1:0] irq_lines_i,
    input  logic [2:0]        op_kind_i,
    input  logic [XLEN-1:0]   op_wdata_i,
    input  logic [XLEN-1:0]   pc_i,
    output logic              take_o,
    output logic [VEC_W-1:0]  vec_off_o,
    output logic              redirect_o,
    output logic [XLEN-1:0]   redirect_pc_o,
    output logic [XLEN-1:0]   status_o,
    output logic [XLEN-1:0]   cause_o,
    output logic [XLEN-1:0]   epc_o
);
    localparam int unsigned IP_HI = CAUSE_IP_LO + NLINES - 1;

    typedef struct packed {
        logic [XLEN-1:0]  status;
        logic [XLEN-1:0]  cause;
        logic [XLEN-1:0]  epc;
        logic             take;
        logic [VEC_W-1:0] vec;
        logic             redir;
        logic [XLEN-1:0]  rpc;
    } state_t;

    state_t cur_q, nxt_d;

    logic [NLINES-1:0] lines_sync;
    logic              priv_ok;
    logic              pend;
    logic              fire;
    op_kind_e          op;

    assign op = op_kind_e'(op_kind_i);

    irq_line_sync #(
        .NLINES (NLINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .line_i (irq_lines_i),
        .line_o (lines_sync)
    );

    irq_priv_check #(
        .XLEN (XLEN)
    ) u_priv (
        .status_i     (cur_q.status),
        .may_toggle_o (priv_ok)
    );

    irq_take_logic #(
        .XLEN      (XLEN),
        .QUAL_MASK (QUAL_MASK)
    ) u_take (
        .status_i  (cur_q.status),
        .cause_i   (cur_q.cause),
        .pending_o (pend),
        .fire_o    (fire)
    );

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.take  = 1'b0;
        nxt_d.vec   = '0;
        nxt_d.redir = 1'b0;
        nxt_d.rpc   = '0;
        nxt_d.cause = '0;
        nxt_d.cause[IP_HI:CAUSE_IP_LO] = lines_sync;

        if (fire) begin
            // exception wins over any operation in the same cycle
            nxt_d.status[SR_EXL] = 1'b1;
            nxt_d.epc            = pc_i;
            nxt_d.take           = 1'b1;
            nxt_d.vec            = VEC_OFF;
        end else begin
            unique case (op)
                OP_EI:   if (priv_ok) nxt_d.status[SR_EIE] = 1'b1;
                OP_DI:   if (priv_ok) nxt_d.status[SR_EIE] = 1'b0;
                OP_ERET: begin
                    nxt_d.status[SR_EXL] = 1'b0;
                    nxt_d.redir          = 1'b1;
                    nxt_d.rpc            = cur_q.epc;
                end
                OP_MTSR: nxt_d.status = op_wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= nxt_d;
    end

    assign take_o        = cur_q.take;
    assign vec_off_o     = cur_q.vec;
    assign redirect_o    = cur_q.redir;
    assign redirect_pc_o = cur_q.rpc;
    assign status_o      = cur_q.status;
    assign cause_o       = cur_q.cause;
    assign epc_o         = cur_q.epc;

    // Checks beside the logic they guard

    assert_take_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_o |=> !take_o);

    assert_epc_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_o |-> (epc_o == $past(pc_i)));

    assert_take_enabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_o |-> $past(status_o[SR_IE] && status_o[SR_EIE] &&
                         !status_o[SR_EXL] && !status_o[SR_ERL]));

    assert_qualified_pending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_o |-> $past(|(cause_o & status_o & QUAL_MASK)));

    assert_unpriv_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((op == OP_EI || op == OP_DI) && !priv_ok && !fire)
        |=> (status_o == $past(status_o)));

    assert_eret_target_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_o |-> (!status_o[SR_EXL] && redirect_pc_o == $past(epc_o)));

    assert_exc_beats_op_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_o |-> (status_o == ($past(status_o) | (XLEN'(1) << SR_EXL))));

endmodule

// File: tb/irq_gate_ctl_tb_top.sv
`timescale 1ns/1ps
module irq_gate_ctl_tb_top;
    import irq_gate_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  lines = '0;
    logic [2:0]  op_kind = '0;
    logic [31:0] op_wdata = '0;
    logic [31:0] pc = '0;
    logic        take;
    logic [11:0] vec;
    logic        redir;
    logic [31:0] rpc, st, cause, epc;

    always #2 clk = ~clk;

    irq_gate_ctl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines),
        .op_kind_i(op_kind), .op_wdata_i(op_wdata), .pc_i(pc),
        .take_o(take), .vec_off_o(vec), .redirect_o(redir),
        .redirect_pc_o(rpc), .status_o(st), .cause_o(cause), .epc_o(epc)
    );

    typedef struct {
        int          due;
        string       req;
        logic        take;
        logic [11:0] vec;
        logic        redir;
        logic [31:0] rpc, st, cause, epc;
    } exp_t;

    exp_t sbq[$];
    int checks = 0;
    int fails = 0;
    int cyc_cnt = 0;
    bit done = 0;

    // reference state built from the requirements
    logic [31:0] m_st = '0, m_cause = '0, m_epc = '0, pc_ctr = 32'h1000;
    logic [7:0]  m_sync = '0;

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    task automatic cyc(input logic [2:0] k, input logic [31:0] wd,
                       input logic [7:0] ln, input string req);
        exp_t e;
        logic fire, priv;
        logic [31:0] nst, nepc;
        @(negedge clk);
        pc_ctr   = pc_ctr + 4;
        op_kind  = k; op_wdata = wd; lines = ln; pc = pc_ctr;
        fire = (|(m_cause & m_st & 32'h0000_FC00)) && m_st[0] && m_st[16]
               && !m_st[1] && !m_st[2];
        priv = m_st[1] | m_st[2] | m_st[17] | (m_st[4:3] == 2'b00);
        nst = m_st; nepc = m_epc;
        e.take = fire; e.vec = fire ? 12'h200 : 12'h000;
        e.redir = 1'b0; e.rpc = '0;
        if (fire) begin
            nst[1] = 1'b1; nepc = pc_ctr;
        end else begin
            case (k)
                3'd1: if (priv) nst[16] = 1'b1;
                3'd2: if (priv) nst[16] = 1'b0;
                3'd3: begin nst[1] = 1'b0; e.redir = 1'b1; e.rpc = m_epc; end
                3'd4: nst = wd;
                default: ;
            endcase
        end
        m_cause = {16'h0, m_sync, 8'h00};
        m_sync  = ln;
        m_st    = nst;
        m_epc   = nepc;
        e.st = m_st; e.cause = m_cause; e.epc = m_epc;
        e.due = cyc_cnt + 1; e.req = req;
        sbq.push_back(e);
    endtask

    // monitor: compare outputs against queued expectations
    always @(negedge clk) begin
        if (sbq.size() > 0 && sbq[0].due == cyc_cnt) begin
            exp_t e;
            e = sbq.pop_front();
            checks++;
            if (take !== e.take || vec !== e.vec || redir !== e.redir ||
                rpc !== e.rpc || st !== e.st || cause !== e.cause || epc !== e.epc) begin
                fails++;
                $display("FAIL %s: got take=%b vec=%h redir=%b rpc=%h st=%h cause=%h epc=%h exp take=%b vec=%h redir=%b rpc=%h st=%h cause=%h epc=%h",
                         e.req, take, vec, redir, rpc, st, cause, epc,
                         e.take, e.vec, e.redir, e.rpc, e.st, e.cause, e.epc);
            end
        end
    end

    task automatic check_idle(input string req);
        checks++;
        if (take !== 1'b0 || redir !== 1'b0 || st !== '0 || cause !== '0 || epc !== '0) begin
            fails++;
            $display("FAIL %s: got take=%b redir=%b st=%h cause=%h epc=%h exp all zero",
                     req, take, redir, st, cause, epc);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 after reset");

        cyc(3'd4, 32'h0001_FF01, 8'h00, "R11 status load");
        for (int i = 0; i < 4; i++) cyc(3'd0, 0, 8'h03, "R3 lines 0,1 never fire / R2 sync");
        cyc(3'd0, 0, 8'h00, "R2 cause clears");
        cyc(3'd0, 0, 8'h00, "R2 cause clears");

        cyc(3'd4, 32'h0000_FC01, 8'h00, "R11 load without EIE");
        for (int i = 0; i < 3; i++) cyc(3'd0, 0, 8'h04, "R4 EIE clear blocks");
        cyc(3'd1, 0, 8'h04, "R6 EI in kernel");
        cyc(3'd0, 0, 8'h04, "R5 take with vector");
        for (int i = 0; i < 3; i++) cyc(3'd0, 0, 8'h04, "R5 no retake under EXL");
        cyc(3'd3, 0, 8'h04, "R9 return with redirect");
        cyc(3'd0, 0, 8'h04, "R9 pending retaken");
        cyc(3'd0, 0, 8'h00, "R5 single pulse");
        cyc(3'd3, 0, 8'h00, "R9 return no pending");
        cyc(3'd0, 0, 8'h00, "R9 idle after return");

        cyc(3'd4, 32'h0001_0011, 8'h00, "R11 user mode load");
        cyc(3'd2, 0, 8'h00, "R8 DI in user ignored");
        cyc(3'd4, 32'h0000_0011, 8'h00, "R11 user mode load");
        cyc(3'd1, 0, 8'h00, "R8 EI in user ignored");
        cyc(3'd0, 0, 8'h00, "R11 code 0 no change");
        cyc(3'd4, 32'h0002_0011, 8'h00, "R11 permission bit load");
        cyc(3'd1, 0, 8'h00, "R6 EI with permission bit");
        cyc(3'd2, 0, 8'h00, "R7 DI with permission bit");
        cyc(3'd4, 32'h0000_0013, 8'h00, "R11 EXL user load");
        cyc(3'd1, 0, 8'h00, "R6 EI under EXL");
        cyc(3'd2, 0, 8'h00, "R7 DI under EXL");

        cyc(3'd4, 32'h0001_FC05, 8'h80, "R11 ERL load");
        for (int i = 0; i < 3; i++) cyc(3'd0, 0, 8'h80, "R4 ERL blocks");
        cyc(3'd2, 0, 8'h80, "R7 DI under ERL");
        cyc(3'd0, 0, 8'h00, "R4 drain");
        cyc(3'd0, 0, 8'h00, "R4 drain");

        cyc(3'd4, 32'h0001_FC01, 8'h00, "R11 enable all");
        cyc(3'd0, 0, 8'h20, "R10 raise line 5");
        cyc(3'd0, 0, 8'h20, "R10 sync");
        cyc(3'd2, 0, 8'h20, "R10 exception beats DI");
        cyc(3'd0, 0, 8'h00, "R10 after collision");
        cyc(3'd3, 0, 8'h00, "R9 return");
        cyc(3'd0, 0, 8'h00, "R9 idle");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got no completion exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule